// File: doc/BRIEF.md
# Copy-Protection and Aspect-Ratio Line Signaller

This block produces the serial bit streams that mark analog video with copy-control information (CGMS, for 525-line output) or wide-screen signalling (WSS, for 625-line output). The timing logic feeds it a line number, a field flag, a start-of-line pulse and a sample strobe. On the chosen blanking line it drives a level-select flag and an active flag into the luma path. The luma path turns these into the white or black level of the inserted waveform.

The control registers supply the payloads, the enables and the standard select. For CGMS the six check bits can come from the registers as written, or the block can compute them from the first fourteen payload bits. The block captures all payload data when a line starts, so later register writes cannot corrupt a line that is already being sent.

Top module: `vbi_sig_inserter`

## Requirements
- R1: After reset both `active` and `lvl_hi` are 0.
- R2: With `pal_mode`=0 a CGMS line starts when `line_start` is high on line 20 with `field_odd`=1 and `cgms_odd_en`=1, or on line 283 with `field_odd`=0 and `cgms_even_en`=1. No other line, field or enable combination starts it.
- R3: A CGMS line is 21 elements, each held for CGMS_ELEM_LEN sample strobes. Element 0 is a reference pulse at high level. Elements 1..20 carry word bits 0..19, least significant first. `active` is high from the cycle after the start until the last element ends.
- R4: With `crc_auto`=1, word bits 14..19 are replaced by crc[0..5]. The crc is computed with generator x^6+x+1 and preset 6'h3F over word bits 0..13 in that order. Each step is fb=crc[5]^bit, then a left shift, then XOR 6'h03 when fb=1.
- R5: With `crc_auto`=0 all 20 register bits are sent unchanged.
- R6: With `pal_mode`=1 and `wss_en`=1, a WSS line starts when `line_start` is high on line 23. It is 137 elements, each held for WSS_ELEM_LEN strobes. The first 29 elements are the run-in 11111000111000111000111000111. The next 24 are the start code 000111100011110000011111. Then come 14 data bits, least significant first.
- R7: Each WSS data bit becomes six elements: 1 is sent as 111000 and 0 as 000111.
- R8: CGMS is never sent with `pal_mode`=1, and WSS is never sent with `pal_mode`=0.
- R9: The element position advances only on cycles with `sample_en`=1. While the strobe is low, the outputs hold.
- R10: Payload and crc mode are captured at the start of a line. Register changes and further `line_start` pulses during an active line have no effect on that line.
- R11: `lvl_hi` is 0 whenever `active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| cgms_odd_en | input | 1 | Enable CGMS on the odd field |
| cgms_even_en | input | 1 | Enable CGMS on the even field |
| crc_auto | input | 1 | Compute the CGMS check bits internally |
| cgms_bits | input | 20 | CGMS payload register |
| wss_en | input | 1 | Enable WSS |
| wss_bits | input | 14 | WSS payload register |
| line_num | input | LINE_W | Current line number |
| field_odd | input | 1 | 1 during the odd field |
| line_start | input | 1 | One-cycle pulse at the start of a line |
| sample_en | input | 1 | Sample strobe that advances the element timing |
| lvl_hi | output | 1 | Inserted level is high |
| active | output | 1 | Insertion window open |

## Verification
A faulty element index or sample counter shows up at once on `lvl_hi`. The reference pulse or run-in moves, and the `active` window gets longer or shorter than elements times length. Both are visible within one line. A wrong crc register or a wrong capture corrupts only the last six CGMS elements, or only the biphase section of WSS. Bad trigger decoding shows as `active` rising on the wrong line, or not rising at all, one cycle after the start pulse.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
    localparam int CGMS_BITS  = 20;
    localparam int CRC_BITS   = 6;
    localparam int CRC_COVER  = CGMS_BITS - CRC_BITS;
    localparam int WSS_BITS   = 14;
    localparam int RUNIN_N    = 29;
    localparam int START_N    = 24;
    localparam int BIPHASE_N  = 6;
    localparam int CGMS_ELEMS = 1 + CGMS_BITS;
    localparam int WSS_HDR    = RUNIN_N + START_N;
    localparam int WSS_ELEMS  = WSS_HDR + WSS_BITS * BIPHASE_N;
    localparam int IDX_W      = $clog2(WSS_ELEMS);

    // element 0 sits in the most significant position
    localparam logic [RUNIN_N-1:0] RUNIN_PAT = 29'b11111000111000111000111000111;
    localparam logic [START_N-1:0] START_PAT = 24'b000111100011110000011111;
    localparam logic [CRC_BITS-1:0] CRC_PRESET = 6'h3F;
    localparam logic [CRC_BITS-1:0] CRC_TAPS   = 6'h03;
endpackage

// File: rtl/vbi_crc6.sv
module vbi_crc6
    import vbi_pkg::*;
(
    input  logic [CRC_COVER-1:0] data,
    output logic [CRC_BITS-1:0]  crc
);
    always_comb begin
        logic [CRC_BITS-1:0] c;
        logic fb;
        c = CRC_PRESET;
        for (int i = 0; i < CRC_COVER; i++) begin
            fb = c[CRC_BITS-1] ^ data[i];
            c  = {c[CRC_BITS-2:0], 1'b0};
            if (fb) c = c ^ CRC_TAPS;
        end
        crc = c;
    end
endmodule

// File: rtl/vbi_cgms_elem.sv
module vbi_cgms_elem
    import vbi_pkg::*;
(
    input  logic [CGMS_BITS-1:0] word,
    input  logic [IDX_W-1:0]     idx,
    output logic                 level
);
    always_comb begin
        int pos;
        pos = int'(idx);
        if (pos == 0)              level = 1'b1;
        else if (pos <= CGMS_BITS) level = word[pos-1];
        else                       level = 1'b0;
    end
endmodule

// File: rtl/vbi_wss_elem.sv
module vbi_wss_elem
    import vbi_pkg::*;
(
    input  logic [WSS_BITS-1:0] word,
    input  logic [IDX_W-1:0]    idx,
    output logic                level
);
    always_comb begin
        int pos, rel, bnum, phase;
        pos   = int'(idx);
        rel   = pos - WSS_HDR;
        bnum  = 0;
        phase = 0;
        if (pos < RUNIN_N) begin
            level = RUNIN_PAT[RUNIN_N-1-pos];
        end else if (pos < WSS_HDR) begin
            level = START_PAT[START_N-1-(pos-RUNIN_N)];
        end else if (pos < WSS_ELEMS) begin
            bnum  = rel / BIPHASE_N;
            phase = rel % BIPHASE_N;
            if (word[bnum]) level = (phase < BIPHASE_N/2);
            else            level = (phase >= BIPHASE_N/2);
        end else begin
            level = 1'b0;
        end
    end
endmodule

// File: rtl/vbi_sig_inserter.sv
module vbi_sig_inserter
    import vbi_pkg::*;
#(
    parameter int LINE_W         = 10,
    parameter int CGMS_LINE_ODD  = 20,
    parameter int CGMS_LINE_EVEN = 283,
    parameter int WSS_LINE       = 23,
    parameter int CGMS_ELEM_LEN  = 4,
    parameter int WSS_ELEM_LEN   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pal_mode,
    input  logic                 cgms_odd_en,
    input  logic                 cgms_even_en,
    input  logic                 crc_auto,
    input  logic [CGMS_BITS-1:0] cgms_bits,
    input  logic                 wss_en,
    input  logic [WSS_BITS-1:0]  wss_bits,
    input  logic [LINE_W-1:0]    line_num,
    input  logic                 field_odd,
    input  logic                 line_start,
    input  logic                 sample_en,
    output logic                 lvl_hi,
    output logic                 active
);
    localparam int MAX_LEN = (CGMS_ELEM_LEN > WSS_ELEM_LEN) ? CGMS_ELEM_LEN : WSS_ELEM_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] CGMS_CNT_LAST = CNT_W'(CGMS_ELEM_LEN - 1);
    localparam logic [CNT_W-1:0] WSS_CNT_LAST  = CNT_W'(WSS_ELEM_LEN - 1);
    localparam logic [IDX_W-1:0] CGMS_IDX_LAST = IDX_W'(CGMS_ELEMS - 1);
    localparam logic [IDX_W-1:0] WSS_IDX_LAST  = IDX_W'(WSS_ELEMS - 1);

    typedef struct packed {
        logic                 run;
        logic                 is_wss;
        logic [IDX_W-1:0]     idx;
        logic [CNT_W-1:0]     cnt;
        logic [CGMS_BITS-1:0] cgms_word;
        logic [WSS_BITS-1:0]  wss_word;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CRC_BITS-1:0]  crc_val;
    logic [CGMS_BITS-1:0] cgms_full;
    logic                 cgms_lvl, wss_lvl;
    logic                 hit_cgms, hit_wss;
    logic [CNT_W-1:0]     cnt_last;
    logic [IDX_W-1:0]     idx_last;

    vbi_crc6 u_crc (
        .data (cgms_bits[CRC_COVER-1:0]),
        .crc  (crc_val)
    );

    vbi_cgms_elem u_cgms (
        .word  (seq_q.cgms_word),
        .idx   (seq_q.idx),
        .level (cgms_lvl)
    );

    vbi_wss_elem u_wss (
        .word  (seq_q.wss_word),
        .idx   (seq_q.idx),
        .level (wss_lvl)
    );

    always_comb begin
        cgms_full = crc_auto ? {crc_val, cgms_bits[CRC_COVER-1:0]} : cgms_bits;
        hit_cgms  = !pal_mode &&
                    (( field_odd && cgms_odd_en  && line_num == LINE_W'(CGMS_LINE_ODD)) ||
                     (!field_odd && cgms_even_en && line_num == LINE_W'(CGMS_LINE_EVEN)));
        hit_wss   = pal_mode && wss_en && line_num == LINE_W'(WSS_LINE);
        cnt_last  = seq_q.is_wss ? WSS_CNT_LAST : CGMS_CNT_LAST;
        idx_last  = seq_q.is_wss ? WSS_IDX_LAST : CGMS_IDX_LAST;

        seq_d = seq_q;
        if (!seq_q.run) begin
            if (line_start && (hit_cgms || hit_wss)) begin
                seq_d.run       = 1'b1;
                seq_d.is_wss    = hit_wss;
                seq_d.idx       = '0;
                seq_d.cnt       = '0;
                seq_d.cgms_word = cgms_full;
                seq_d.wss_word  = wss_bits;
            end
        end else if (sample_en) begin
            if (seq_q.cnt == cnt_last) begin
                seq_d.cnt = '0;
                if (seq_q.idx == idx_last) seq_d.run = 1'b0;
                else                       seq_d.idx = seq_q.idx + 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign active = seq_q.run;
    assign lvl_hi = seq_q.run & (seq_q.is_wss ? wss_lvl : cgms_lvl);

    // R11: no level while the window is closed
    p_dark_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !lvl_hi);

    // R9: position frozen while the strobe is low
    p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && !sample_en) |=> (seq_q.run && $stable(seq_q.idx) && $stable(seq_q.cnt)));

    // R2 / R6: a line only opens after a start pulse
    p_open_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(line_start));

    // R3: reference pulse at high level
    p_ref_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && !seq_q.is_wss && seq_q.idx == '0) |-> lvl_hi);

    // R6: first run-in element is high
    p_runin_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && seq_q.is_wss && seq_q.idx == '0) |-> lvl_hi);

    // R10: captured payload is stable for the whole line
    p_capture_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && $past(seq_q.run)) |-> ($stable(seq_q.cgms_word) && $stable(seq_q.wss_word) && $stable(seq_q.is_wss)));
endmodule

// File: tb/tb_vbi_sig_inserter.sv
module tb_vbi_sig_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int CLEN = 4;
    localparam int WLEN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_mode = 1'b0, cgms_odd_en = 1'b0, cgms_even_en = 1'b0, crc_auto = 1'b0;
    logic [19:0] cgms_bits = '0;
    logic        wss_en = 1'b0;
    logic [13:0] wss_bits = '0;
    logic [9:0]  line_num = '0;
    logic        field_odd = 1'b0, line_start = 1'b0, sample_en = 1'b1;
    logic        lvl_hi, active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_sig_inserter #(
        .LINE_W(10), .CGMS_LINE_ODD(20), .CGMS_LINE_EVEN(283), .WSS_LINE(23),
        .CGMS_ELEM_LEN(CLEN), .WSS_ELEM_LEN(WLEN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .cgms_odd_en(cgms_odd_en),
        .cgms_even_en(cgms_even_en), .crc_auto(crc_auto), .cgms_bits(cgms_bits),
        .wss_en(wss_en), .wss_bits(wss_bits), .line_num(line_num), .field_odd(field_odd),
        .line_start(line_start), .sample_en(sample_en), .lvl_hi(lvl_hi), .active(active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] ref_crc(input logic [13:0] d);
        logic [5:0] c = 6'h3F;
        for (int i = 0; i < 14; i++) begin
            logic fb = c[5] ^ d[i];
            c = {c[4:0], 1'b0};
            if (fb) c = c ^ 6'h03;
        end
        return c;
    endfunction

    function automatic bit exp_elem(input bit w, input logic [19:0] cw, input logic [13:0] ww, input int e);
        logic [28:0] runin = 29'b11111000111000111000111000111;
        logic [23:0] start = 24'b000111100011110000011111;
        if (!w) return (e == 0) ? 1'b1 : cw[e-1];
        if (e < 29) return runin[28-e];
        if (e < 53) return start[23-(e-29)];
        if (ww[(e-53)/6]) return ((e-53)%6) < 3;
        return ((e-53)%6) >= 3;
    endfunction

    task automatic begin_line(input logic [9:0] ln, input logic odd);
        @(negedge clk);
        line_num = ln; field_odd = odd; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // called at the first negedge after the start edge; checks the whole line
    task automatic expect_frame(input bit w, input logic [19:0] cw, input logic [13:0] ww,
                                input string req, input bit disturb);
        int n   = w ? 137 : 21;
        int len = w ? WLEN : CLEN;
        int bad = 0;
        for (int e = 0; e < n; e++) begin
            for (int s = 0; s < len; s++) begin
                bit ex = exp_elem(w, cw, ww, e);
                if (s > 0 || e > 0) @(negedge clk);
                if (line_start) line_start = 1'b0;
                chk(active === 1'b1 && lvl_hi === ex, req, {30'd0, active, lvl_hi}, {30'd0, 1'b1, ex});
                if (disturb && e == 3 && s == 0) begin
                    cgms_bits = ~cgms_bits; wss_bits = ~wss_bits; line_start = 1'b1;
                end
            end
        end
        @(negedge clk);
        chk(active === 1'b0 && lvl_hi === 1'b0, req, {30'd0, active, lvl_hi}, 0);
        if (bad != 0) failures++;
    endtask

    task automatic expect_idle(input string req);
        for (int i = 0; i < 4; i++) begin
            chk(active === 1'b0 && lvl_hi === 1'b0, req, {30'd0, active, lvl_hi}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(active === 1'b0 && lvl_hi === 1'b0, "R1", {30'd0, active, lvl_hi}, 0);
    endtask

    task automatic t_cgms_odd_crc;
        logic [19:0] w;
        pal_mode = 0; cgms_odd_en = 1; cgms_even_en = 0; crc_auto = 1;
        cgms_bits = 20'hA5C3B;
        w = {ref_crc(cgms_bits[13:0]), cgms_bits[13:0]};
        begin_line(10'd20, 1'b1);
        expect_frame(1'b0, w, '0, "R2 R3 R4 odd crc", 1'b0);
    endtask

    task automatic t_cgms_even_raw;
        pal_mode = 0; cgms_odd_en = 0; cgms_even_en = 1; crc_auto = 0;
        cgms_bits = 20'hF0C69;
        begin_line(10'd283, 1'b0);
        expect_frame(1'b0, 20'hF0C69, '0, "R5 R2 even raw", 1'b0);
    endtask

    task automatic t_enable_gating;
        pal_mode = 0; cgms_odd_en = 0; cgms_even_en = 1;
        begin_line(10'd20, 1'b1);   expect_idle("R2 odd disabled");
        cgms_odd_en = 1;
        begin_line(10'd21, 1'b1);   expect_idle("R2 wrong line");
        cgms_even_en = 0;
        begin_line(10'd283, 1'b0);  expect_idle("R2 even disabled");
        cgms_even_en = 1;
        begin_line(10'd283, 1'b1);  expect_idle("R2 wrong field");
    endtask

    task automatic t_pal_wss;
        pal_mode = 1; wss_en = 1; wss_bits = 14'h2A5B;
        begin_line(10'd23, 1'b1);
        expect_frame(1'b1, '0, 14'h2A5B, "R6 R7 wss", 1'b0);
        wss_bits = 14'h0001;
        begin_line(10'd23, 1'b0);
        expect_frame(1'b1, '0, 14'h0001, "R7 biphase", 1'b0);
    endtask

    task automatic t_std_gating;
        pal_mode = 1; cgms_odd_en = 1; wss_en = 1;
        begin_line(10'd20, 1'b1);  expect_idle("R8 cgms in pal");
        pal_mode = 0;
        begin_line(10'd23, 1'b1);  expect_idle("R8 wss in ntsc");
    endtask

    task automatic t_strobe;
        pal_mode = 0; cgms_odd_en = 1; crc_auto = 0; cgms_bits = 20'h12345;
        sample_en = 0;
        begin_line(10'd20, 1'b1);
        for (int i = 0; i < 6; i++) begin
            chk(active === 1'b1 && lvl_hi === 1'b1, "R9 hold", {30'd0, active, lvl_hi}, 3);
            @(negedge clk);
        end
        sample_en = 1;
        expect_frame(1'b0, 20'h12345, '0, "R9 resume", 1'b0);
    endtask

    task automatic t_latch;
        pal_mode = 0; cgms_odd_en = 1; crc_auto = 1; cgms_bits = 20'h0BEEF;
        begin_line(10'd20, 1'b1);
        expect_frame(1'b0, {ref_crc(14'h3EEF), 14'h3EEF}, '0, "R10 cgms latch", 1'b1);
        pal_mode = 1; wss_en = 1; wss_bits = 14'h1234; line_num = 10'd23;
        begin_line(10'd23, 1'b1);
        expect_frame(1'b1, '0, 14'h1234, "R10 wss latch", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cgms_odd_crc();
        t_cgms_even_raw();
        t_enable_gating();
        t_pal_wss();
        t_std_gating();
        t_strobe();
        t_latch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule